// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Write Port

This block is the write side of a separate-I/O SRAM whose every write moves a fixed burst of two words. The command and its address are taken on consecutive rising edges of the forward clock `clk`. Its two data beats arrive at twice the command rate. The first beat is taken on the same edge as the command. The second beat is taken on the rising edge of the inverted clock `clkN` that falls between the command edge and the address edge. On the address edge, both beats are written into the storage array: the first at the loaded address and the second at that address plus one.

Each data word is 18 bits, arranged as two 9-bit byte lanes. Each beat carries its own pair of active-low byte enables, so one address load can commit up to 36 bits with any mix of lanes masked. A high write strobe on a command edge is a deselect cycle and stores nothing. Because the address phase of one write overlaps the command phase of the next, writes can be issued on every clock with no idle cycle. An asynchronous inspection port (`peekAddr` and `peekData`) exposes the array so that its contents can be observed.

Top module: `ddr_burst_write_port`

## Requirements
- R1: `writeN` is sampled on every rising edge of `clk`, and a low level there starts a write command.
- R2: The first data beat and its byte enables are taken from `dataIn` and `byteEnN` on the same `clk` edge that takes the command.
- R3: The second data beat and its byte enables are taken on the rising edge of `clkN` that follows the command edge.
- R4: The base address is taken from `addr` on the next rising `clk` edge after the command edge, and both beats become visible on `peekData` right after that edge.
- R5: A high `writeN` on a command edge is a deselect cycle, and on the following edge no array location changes.
- R6: `byteEnN` bit 0 governs data bits 8:0 and bit 1 governs data bits 17:9. A high enable bit leaves that lane of the target word unchanged, and a low bit stores the lane.
- R7: Beat one is stored at the base address and beat two at base plus one, modulo the array depth of 2^ADDR_W words, so base 2^ADDR_W-1 puts beat two at address 0.
- R8: Write commands on consecutive `clk` edges are all accepted with no bubble. Each edge can carry the address of one write and the command of the next.
- R9: The masks of the two beats are independent, so any of the 16 enable combinations across both beats stores exactly the unmasked lanes.
- R10: While `rstN` is low no command is accepted, and a command whose address edge has not yet occurred when reset is asserted is dropped without storing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forward clock; command and address edges |
| clkN | input | 1 | Inverted clock; its rising edge takes the second data beat |
| rstN | input | 1 | Asynchronous active-low reset of the command pipeline |
| writeN | input | 1 | Active-low write command strobe |
| addr | input | ADDR_W | Base address, taken one edge after the command |
| dataIn | input | 18 | Data-in bus, two 9-bit lanes |
| byteEnN | input | 2 | Active-low per-lane write enables, one bit per lane |
| peekAddr | input | ADDR_W | Inspection address for the storage array |
| peekData | output | 18 | Array word at `peekAddr`, read combinationally |

## Verification
The array is first filled by an unbroken chain of back-to-back writes with distinct beats, which separates the beat-one and beat-two paths and would expose a dropped or shifted command. Writes are then repeated over all sixteen two-beat mask combinations at one address pair, which tells lane 0 from lane 1 and beat one from beat two. A base at the top address shows whether beat two wraps to address 0. Deselect cycles with live data on the bus, and a command cut off by reset, show that nothing is stored without a complete command. A long random mix of masked writes and deselects ends in a full comparison of the array against a lane-level model.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  // Strobes from the command control to the datapath
  typedef struct packed {
    logic loadBeat0;  // command edge: capture first beat and its enables
    logic commit;     // address edge: write both beats into the array
  } wr_strobe_t;

endpackage

// File: rtl/ddrw_ctrl.sv
module ddrw_ctrl
  import ddrw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       writeN,
  output wr_strobe_t strobe
);

  logic cmdPend;

  // A command seen on this edge becomes a commit on the next edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPend <= 1'b0;
    else       cmdPend <= ~writeN;
  end

  always_comb begin
    strobe.loadBeat0 = ~writeN & rstN;
    strobe.commit    = cmdPend;
  end

endmodule

// File: rtl/ddrw_array.sv
module ddrw_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                         clk,
  input  logic [LANES-1:0]             weLo,
  input  logic [ADDR_W-1:0]            addrLo,
  input  logic [LANES-1:0][LANE_W-1:0] dataLo,
  input  logic [LANES-1:0]             weHi,
  input  logic [ADDR_W-1:0]            addrHi,
  input  logic [LANES-1:0][LANE_W-1:0] dataHi,
  input  logic [ADDR_W-1:0]            peekAddr,
  output logic [LANES-1:0][LANE_W-1:0] peekData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  // Two lane-masked write ports; the two addresses always differ by one
  always_ff @(posedge clk) begin
    for (int ln = 0; ln < LANES; ln++) begin
      if (weLo[ln]) mem[addrLo][ln] <= dataLo[ln];
      if (weHi[ln]) mem[addrHi][ln] <= dataHi[ln];
    end
  end

  assign peekData = mem[peekAddr];

endmodule

// File: rtl/ddrw_datapath.sv
module ddrw_datapath
  import ddrw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              clkN,
  input  logic              rstN,
  input  wr_strobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData
);

  logic [DATA_W-1:0] beat0Data, beat1Data;
  logic [LANES-1:0]  beat0MaskN, beat1MaskN;
  logic [LANES-1:0]  weLo, weHi;
  logic [ADDR_W-1:0] addrHi;

  // First beat rides with the command on the forward clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat0Data  <= '0;
      beat0MaskN <= '1;
    end else if (strobe.loadBeat0) begin
      beat0Data  <= dataIn;
      beat0MaskN <= byteEnN;
    end
  end

  // Second beat is taken half a cycle later on the inverted clock
  always_ff @(posedge clkN or negedge rstN) begin
    if (!rstN) begin
      beat1Data  <= '0;
      beat1MaskN <= '1;
    end else begin
      beat1Data  <= dataIn;
      beat1MaskN <= byteEnN;
    end
  end

  // Per-lane enables for each beat
  for (genvar g = 0; g < LANES; g++) begin : g_laneEn
    assign weLo[g] = strobe.commit & ~beat0MaskN[g];
    assign weHi[g] = strobe.commit & ~beat1MaskN[g];
  end

  // Upper word address wraps naturally over the power-of-two depth
  assign addrHi = addr + ADDR_W'(1);

  ddrw_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk     (clk),
    .weLo    (weLo),
    .addrLo  (addr),
    .dataLo  (beat0Data),
    .weHi    (weHi),
    .addrHi  (addrHi),
    .dataHi  (beat1Data),
    .peekAddr(peekAddr),
    .peekData(peekData)
  );

endmodule

// File: rtl/ddr_burst_write_port.sv
module ddr_burst_write_port
  import ddrw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              clkN,
  input  logic              rstN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData
);

  wr_strobe_t strobe;

  ddrw_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .writeN(writeN),
    .strobe(strobe)
  );

  ddrw_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_dp (
    .clk     (clk),
    .clkN    (clkN),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .byteEnN (byteEnN),
    .peekAddr(peekAddr),
    .peekData(peekData)
  );

endmodule

// File: rtl/ddr_burst_write_port_chk.sv
module ddr_burst_write_port_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              writeN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataIn,
  input logic [1:0]        byteEnN,
  input logic [ADDR_W-1:0] peekAddr,
  input logic [DATA_W-1:0] peekData
);

  // Edges since reset release, saturating, so two-deep history is valid
  logic [1:0] warmCnt;
  logic       warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end
  assign warm = (warmCnt == 2'd3);

  // R5
  deselect_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(writeN, 2) && $stable(peekAddr)) |-> $stable(peekData));

  // R2
  beat0_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(writeN, 2) && !$past(byteEnN[0], 2) && peekAddr == $past(addr))
      |-> peekData[8:0] == $past(dataIn[8:0], 2));

  // R6
  lane1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(writeN, 2) && $past(byteEnN[1], 2) && peekAddr == $past(addr)
      && $stable(peekAddr)) |-> peekData[17:9] == $past(peekData[17:9]));

  // R6
  lane0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(writeN, 2) && $past(byteEnN[0], 2) && peekAddr == $past(addr)
      && $stable(peekAddr)) |-> peekData[8:0] == $past(peekData[8:0]));

endmodule

bind ddr_burst_write_port ddr_burst_write_port_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .writeN  (writeN),
  .addr    (addr),
  .dataIn  (dataIn),
  .byteEnN (byteEnN),
  .peekAddr(peekAddr),
  .peekData(peekData)
);

// File: tb/ddr_burst_write_port_test.sv
module ddr_burst_write_port_test;

  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          clkN;
  logic          rstN = 1'b0;
  logic          writeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [17:0]   dataIn = '0;
  logic [1:0]    byteEnN = 2'b11;
  logic [AW-1:0] peekAddr = '0;
  logic [17:0]   peekData;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Reference model
  logic [17:0] model [DEPTH];
  bit          pendValid = 1'b0;
  logic [17:0] pendD0, pendD1;
  logic [1:0]  pendM0, pendM1;

  always #4 clk = ~clk;  // 125 MHz
  assign clkN = ~clk;

  ddr_burst_write_port #(.ADDR_W(AW)) uut (
    .clk(clk), .clkN(clkN), .rstN(rstN), .writeN(writeN), .addr(addr),
    .dataIn(dataIn), .byteEnN(byteEnN), .peekAddr(peekAddr), .peekData(peekData)
  );

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d,
                                        input logic [1:0] mN);
    logic [17:0] r = old;
    if (!mN[0]) r[8:0]  = d[8:0];
    if (!mN[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  // One clk cycle: values for the coming rising clk edge, then the second
  // beat for the following clkN edge. Returns 6 ns after the clk edge.
  task automatic step(input logic wN, input logic [AW-1:0] a,
                      input logic [17:0] dR, input logic [1:0] mR,
                      input logic [17:0] dF, input logic [1:0] mF);
    writeN = wN; addr = a; dataIn = dR; byteEnN = mR;
    @(posedge clk);
    if (rstN && pendValid) begin
      model[a]        = merge(model[a], pendD0, pendM0);
      model[AW'(a+1)] = merge(model[AW'(a+1)], pendD1, pendM1);
    end
    pendValid = rstN && !wN;
    pendD0 = dR; pendM0 = mR; pendD1 = dF; pendM1 = mF;
    #2; dataIn = dF; byteEnN = mF;
    #4;
  endtask

  task automatic idle();
    step(1'b1, '0, '0, 2'b11, '0, 2'b11);
  endtask

  task automatic checkWord(input string tag, input logic [AW-1:0] a);
    peekAddr = a;
    #0.5;
    checks++;
    if (peekData !== model[a]) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, peekData, model[a]);
    end
  endtask

  // R8 R4 R1: fill whole array with an unbroken chain of writes
  task automatic testFill();
    for (int i = 0; i < DEPTH; i += 2) begin
      logic [AW-1:0] prevBase = AW'(i - 2);
      step(1'b0, prevBase, 18'(i * 1111 + 7), 2'b00, 18'(i * 1111 + 901), 2'b00);
    end
    step(1'b1, AW'(DEPTH - 2), '0, 2'b11, '0, 2'b11);
    idle();
    for (int i = 0; i < DEPTH; i++) checkWord("R8", AW'(i));
  endtask

  // R5: deselect cycles with live data change nothing
  task automatic testDeselect();
    for (int i = 0; i < 4; i++)
      step(1'b1, AW'(3 + i), 18'h3ffff, 2'b00, 18'h2aaaa, 2'b00);
    idle();
    for (int i = 3; i < 8; i++) checkWord("R5", AW'(i));
  endtask

  // R6 R9 R2 R3: every two-beat mask combination at one address pair
  task automatic testMasks();
    for (int m = 0; m < 16; m++) begin
      step(1'b0, '0, 18'(m * 20011 + 5), 2'(m), 18'(m * 7919 + 3), 2'(m >> 2));
      step(1'b1, AW'(10), '0, 2'b11, '0, 2'b11);
      checkWord("R6", AW'(10));
      checkWord("R9", AW'(11));
    end
    // lane 0 only on beat one, lane 1 only on beat two
    step(1'b0, '0, 18'h155aa, 2'b10, 18'h0c3f0, 2'b01);
    step(1'b1, AW'(12), '0, 2'b11, '0, 2'b11);
    checkWord("R2", AW'(12));
    checkWord("R3", AW'(13));
  endtask

  // R7: base at top address wraps beat two to address 0
  task automatic testWrap();
    step(1'b0, '0, 18'h1e1e1, 2'b00, 18'h0f0f0, 2'b00);
    step(1'b1, AW'(DEPTH - 1), '0, 2'b11, '0, 2'b11);
    checkWord("R7", AW'(DEPTH - 1));
    checkWord("R7", AW'(0));
  endtask

  // R10: command cut off by reset, and commands held during reset
  task automatic testReset();
    step(1'b0, '0, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00);
    rstN = 1'b0; pendValid = 1'b0;
    step(1'b0, AW'(20), 18'h12345, 2'b00, 18'h12345, 2'b00);
    step(1'b0, AW'(20), 18'h12345, 2'b00, 18'h12345, 2'b00);
    rstN = 1'b1;
    step(1'b1, AW'(20), '0, 2'b11, '0, 2'b11);
    idle();
    checkWord("R10", AW'(20));
    checkWord("R10", AW'(21));
  endtask

  // R8 R6 R7: random masked writes mixed with deselects
  task automatic testRandom();
    logic [AW-1:0] nextAddr = '0;
    for (int i = 0; i < 400; i++) begin
      logic wN = ($urandom_range(0, 3) == 0);
      step(wN, nextAddr, 18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom));
      nextAddr = AW'($urandom);
    end
    step(1'b1, nextAddr, '0, 2'b11, '0, 2'b11);
    idle();
    for (int i = 0; i < DEPTH; i++) checkWord("R8", AW'(i));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #6;
    rstN = 1'b1;
    idle();
    testFill();
    testDeselect();
    testMasks();
    testWrap();
    testReset();
    testRandom();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule